// File: doc/BRIEF.md
# Serial Port Event Interrupt Collector

This block gathers fourteen event sources of a serial port into one sticky status register. Each source owns one status bit. An enable register selects which pending bits may raise the single level-high interrupt line. Software acknowledges an event by writing a one to its status bit. Bits written as zero are left alone.

Most sources arrive as one-cycle pulses from the transmit and receive data paths. Two sources are built inside the block. The first detects a change of level on the clear-to-send input. The second is a receive timeout that fires when the receive FIFO holds data but the line has stayed idle for a set number of character times. A small register port provides access to status, enable and a line-status word. The line-status word shows the synchronized clear-to-send level and a pending summary for the receive group and the transmit group.

Top module: `sirq_hub`

## Requirements
- R1: Status bit i is set by a pulse on `evt_i[i]` for i = 0..9, 12 and 13 (0 tx holding empty, 1 rx holding full, 2 tx FIFO almost empty, 3 tx FIFO empty, 4 rx FIFO almost full, 5 rx FIFO full, 6 tx underrun, 7 rx overrun, 8 parity error, 9 framing error, 12 break finished, 13 bus error). `evt_i[10]` and `evt_i[11]` have no effect.
- R2: A write to address 0 clears exactly the status bits written as one. All other status bits keep their value.
- R3: When an event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Address 1 is a read/write 14-bit enable register. `irq_o` is high one cycle after any bit of (status AND enable) is set, and low one cycle after none is set.
- R5: Either edge of `cts_i` sets status bit 10. The edge is seen after a two-flop synchronizer, so bit 10 reads as one from the third rising clock edge after the change.
- R6: Address 2 reads the line status: bit 4 is the synchronized `cts_i` level, bit 0 is high when any enabled receive-group bit (4, 5, 7, 8, 9, 11) is pending, bit 1 is high when any enabled transmit-group bit (2, 3, 6) is pending. All other bits read as zero.
- R7: While `rx_nempty_i` is high and `rx_busy_i` is low, the fourth `char_tick_i` pulse sets status bit 11 two edges later. The timeout fires only once per idle period. A high `rx_busy_i` or a low `rx_nempty_i` restarts the count.
- R8: After reset, status, enable and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 14 | Event pulses from the data paths, one per status bit |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| rx_nempty_i | input | 1 | Receive FIFO holds at least one entry |
| rx_busy_i | input | 1 | Receiver is currently taking in a character |
| char_tick_i | input | 1 | One pulse per character time |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | High for write, low for read |
| bus_addr_i | input | 2 | Register select: 0 status, 1 enable, 2 line status |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the selected address |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
The hardest case to reach is an event and its acknowledge landing on the same bit in the same cycle. The bench reaches it by driving an event pulse and a status write at the same falling edge. That write also carries a one for an older pending bit, so the bench can see in one read that the clear worked and that the set won. The receive timeout is also hard to reach, because it depends on a counted run of character ticks. The bench steps through those ticks one at a time: it checks that three ticks leave bit 11 clear and that a fifth tick does not fire it again, then restarts the count with a busy pulse.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int NSRC = 14;

  // source positions (software decodes these)
  localparam int SRC_TX_HOLD_EMPTY = 0;
  localparam int SRC_RX_HOLD_FULL  = 1;
  localparam int SRC_TXF_LOW       = 2;
  localparam int SRC_TXF_EMPTY     = 3;
  localparam int SRC_RXF_HIGH      = 4;
  localparam int SRC_RXF_FULL      = 5;
  localparam int SRC_TX_UNDERRUN   = 6;
  localparam int SRC_RX_OVERRUN    = 7;
  localparam int SRC_PARITY        = 8;
  localparam int SRC_FRAMING       = 9;
  localparam int SRC_CTS_CHANGE    = 10;
  localparam int SRC_RX_IDLE       = 11;
  localparam int SRC_BREAK_END     = 12;
  localparam int SRC_BUS_FAULT     = 13;

  localparam int LINE_RX_PEND_BIT = 0;
  localparam int LINE_TX_PEND_BIT = 1;
  localparam int LINE_CTS_BIT     = 4;

  function automatic logic [NSRC-1:0] bitmask(input int idx);
    logic [NSRC-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  function automatic logic [NSRC-1:0] rx_group();
    return bitmask(SRC_RXF_HIGH) | bitmask(SRC_RXF_FULL) | bitmask(SRC_RX_OVERRUN) |
           bitmask(SRC_PARITY) | bitmask(SRC_FRAMING) | bitmask(SRC_RX_IDLE);
  endfunction

  function automatic logic [NSRC-1:0] tx_group();
    return bitmask(SRC_TXF_LOW) | bitmask(SRC_TXF_EMPTY) | bitmask(SRC_TX_UNDERRUN);
  endfunction

  // sources driven only from inside the block
  function automatic logic [NSRC-1:0] internal_srcs();
    return bitmask(SRC_CTS_CHANGE) | bitmask(SRC_RX_IDLE);
  endfunction

  // sticky bit update: event set beats acknowledge
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_pending(input logic [NSRC-1:0] sts,
                                       input logic [NSRC-1:0] en,
                                       input logic [NSRC-1:0] grp);
    return |(sts & en & grp);
  endfunction

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_ENABLE = 2'd1,
    REG_LINE   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/sirq_cts_edge.sv
module sirq_cts_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_async_i,
  output logic cts_lvl_o,
  output logic cts_tgl_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= cts_async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_async_i};
      end
    end
  endgenerate

  assign cts_lvl_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= cts_lvl_o;
  end

  assign cts_tgl_o = cts_lvl_o ^ last_q;

  // R5: both edges of the synchronized level produce a toggle event
  p_rise_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_lvl_o) |-> cts_tgl_o);
  p_fall_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cts_lvl_o) |-> cts_tgl_o);

endmodule

// File: rtl/sirq_rx_idle.sv
module sirq_rx_idle #(
  parameter int TOUT_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_nempty_i,
  input  logic rx_busy_i,
  input  logic char_tick_i,
  output logic idle_evt_o
);
  localparam int CW = $clog2(TOUT_CHARS) + 1;
  localparam logic [CW-1:0] LAST = CW'(TOUT_CHARS - 1);

  logic [CW-1:0] cnt_q;
  logic          fired_q;
  logic          armed;
  logic          reach;

  assign armed = rx_nempty_i & ~rx_busy_i;
  assign reach = armed & char_tick_i & ~fired_q & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      fired_q    <= 1'b0;
      idle_evt_o <= 1'b0;
    end else begin
      idle_evt_o <= reach;
      if (!armed) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (char_tick_i && !fired_q) begin
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          fired_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7: one pulse per idle period, never with an empty FIFO
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt_o |=> !idle_evt_o);
  p_no_evt_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_nempty_i |=> !idle_evt_o);
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/sirq_status_reg.sv
module sirq_status_reg #(
  parameter int NBITS = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] sts_o
);
  import sirq_pkg::*;

  generate
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_o[i] <= 1'b0;
        else        sts_o[i] <= sticky_next(sts_o[i], set_i[i], clr_i[i]);
      end

      // R3: set wins; R2: a lone clear empties the bit; otherwise it holds
      p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> sts_o[i]);
      p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !sts_o[i]);
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i[i] && !set_i[i]) |=> $stable(sts_o[i]));
    end
  endgenerate

endmodule

// File: rtl/sirq_hub.sv
module sirq_hub #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int TOUT_CHARS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [13:0]       evt_i,
  input  logic              cts_i,
  input  logic              rx_nempty_i,
  input  logic              rx_busy_i,
  input  logic              char_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  import sirq_pkg::*;

  localparam logic [NSRC-1:0] EXT_MASK = ~internal_srcs();
  localparam logic [NSRC-1:0] RX_GRP   = rx_group();
  localparam logic [NSRC-1:0] TX_GRP   = tx_group();

  logic            cts_lvl, cts_tgl, idle_evt;
  logic [NSRC-1:0] set_vec, clr_vec, sts, en_q;
  logic            wr_sts, wr_en;
  logic            pend_any, rx_pend, tx_pend;
  logic [DATA_W-1:0] line_w;
  logic            unused_wdata;

  sirq_cts_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_async_i(cts_i),
    .cts_lvl_o  (cts_lvl),
    .cts_tgl_o  (cts_tgl)
  );

  sirq_rx_idle #(.TOUT_CHARS(TOUT_CHARS)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_nempty_i(rx_nempty_i),
    .rx_busy_i  (rx_busy_i),
    .char_tick_i(char_tick_i),
    .idle_evt_o (idle_evt)
  );

  always_comb begin
    set_vec = evt_i & EXT_MASK;
    set_vec[SRC_CTS_CHANGE] = cts_tgl;
    set_vec[SRC_RX_IDLE]    = idle_evt;
  end

  assign wr_sts  = bus_sel_i & bus_wr_i & (bus_addr_i == ADDR_W'(REG_STATUS));
  assign wr_en   = bus_sel_i & bus_wr_i & (bus_addr_i == ADDR_W'(REG_ENABLE));
  assign clr_vec = wr_sts ? bus_wdata_i[NSRC-1:0] : '0;

  sirq_status_reg #(.NBITS(NSRC)) u_sts (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(set_vec),
    .clr_i(clr_vec),
    .sts_o(sts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= bus_wdata_i[NSRC-1:0];
  end

  assign pend_any = any_pending(sts, en_q, '1);
  assign rx_pend  = any_pending(sts, en_q, RX_GRP);
  assign tx_pend  = any_pending(sts, en_q, TX_GRP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend_any;
  end

  always_comb begin
    line_w = '0;
    line_w[LINE_RX_PEND_BIT] = rx_pend;
    line_w[LINE_TX_PEND_BIT] = tx_pend;
    line_w[LINE_CTS_BIT]     = cts_lvl;
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_W'(REG_STATUS): bus_rdata_o = {{(DATA_W-NSRC){1'b0}}, sts};
      ADDR_W'(REG_ENABLE): bus_rdata_o = {{(DATA_W-NSRC){1'b0}}, en_q};
      ADDR_W'(REG_LINE):   bus_rdata_o = line_w;
      default:             bus_rdata_o = '0;
    endcase
  end

  assign unused_wdata = &{1'b0, bus_wdata_i[DATA_W-1:NSRC]};

  // R4: the line follows enabled pending bits one cycle later
  p_irq_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts & en_q)) |=> irq_o);
  p_irq_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts & en_q)) |=> !irq_o);
  // R1: outside pulses on the internal positions never set them
  p_ext_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[SRC_CTS_CHANGE] && !cts_tgl && !sts[SRC_CTS_CHANGE]) |=> !sts[SRC_CTS_CHANGE]);
  // R5 / R7: internal events reach the status register
  p_cts_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cts_tgl |=> sts[SRC_CTS_CHANGE]);
  p_idle_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> sts[SRC_RX_IDLE]);
  // R6: group summaries never report without a global pending bit
  p_grp_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend || tx_pend) |-> pend_any);

endmodule

// File: tb/sirq_hub_bench.sv
`timescale 1ns/1ps
module sirq_hub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] evt = '0;
  logic        cts = 1'b0, nempty = 1'b0, busy = 1'b0, tick = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sirq_hub u_sirq_hub (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cts_i(cts),
    .rx_nempty_i(nempty), .rx_busy_i(busy), .char_tick_i(tick),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // stimulus {events, enable, clear}; expectations follow R1, R2, R4
  localparam logic [41:0] VEC [0:5] = '{
    {14'h0001, 14'h0001, 14'h0000},
    {14'h3FFF, 14'h0000, 14'h0000},
    {14'h2100, 14'h2000, 14'h2000},
    {14'h00F0, 14'h0100, 14'h0010},
    {14'h0C03, 14'h0C00, 14'h0000},
    {14'h1208, 14'h0008, 14'h1000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_evt(input logic [13:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic char_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    logic [13:0] e, en, c, exp_sts;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R8 reset state
    bus_read(2'd0, rd); check("R8 status", rd, 16'h0000);
    bus_read(2'd1, rd); check("R8 enable", rd, 16'h0000);
    check("R8 irq", {15'd0, irq}, 16'h0000);

    // vector table: R1 map, R2 clear, R4 enable/irq
    for (int i = 0; i < 6; i++) begin
      {e, en, c} = VEC[i];
      exp_sts = e & 14'h33FF & ~c;
      bus_write(2'd0, 16'h3FFF);
      bus_write(2'd1, {2'b00, en});
      pulse_evt(e);
      bus_write(2'd0, {2'b00, c});
      bus_read(2'd1, rd); check("R4 enable readback", rd, {2'b00, en});
      bus_read(2'd0, rd); check("R1 R2 status", rd, {2'b00, exp_sts});
      check("R4 irq level", {15'd0, irq}, {15'd0, |(exp_sts & en)});
    end

    // R2: clear drops irq one cycle later
    bus_write(2'd0, 16'h3FFF);
    wait_cyc(1);
    check("R4 irq after clear", {15'd0, irq}, 16'h0000);

    // R3: set and clear same cycle on bit 3, bit 0 cleared meanwhile
    pulse_evt(14'h0001);
    @(negedge clk);
    evt = 14'h0008; sel = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 16'h0009;
    @(negedge clk);
    evt = '0; sel = 1'b0; wr = 1'b0; wdata = '0;
    bus_read(2'd0, rd); check("R3 set wins", rd, 16'h0008);

    // R6 group summaries
    bus_write(2'd0, 16'h3FFF);
    bus_write(2'd1, 16'h0024);
    pulse_evt(14'h0020);
    bus_read(2'd2, rd); check("R6 rx group", rd, 16'h0001);
    pulse_evt(14'h0004);
    bus_read(2'd2, rd); check("R6 both groups", rd, 16'h0003);
    bus_write(2'd0, 16'h3FFF);
    bus_write(2'd1, 16'h0000);

    // R5 CTS rising then falling edge
    @(negedge clk); cts = 1'b1;
    wait_cyc(4);
    bus_read(2'd0, rd); check("R5 rise sets bit10", rd, 16'h0400);
    bus_read(2'd2, rd); check("R6 cts level", rd, 16'h0010);
    bus_write(2'd0, 16'h0400);
    bus_read(2'd0, rd); check("R5 cleared", rd, 16'h0000);
    @(negedge clk); cts = 1'b0;
    wait_cyc(4);
    bus_read(2'd0, rd); check("R5 fall sets bit10", rd, 16'h0400);
    bus_write(2'd0, 16'h3FFF);

    // R7 receive idle timeout
    nempty = 1'b1;
    for (int k = 0; k < 3; k++) char_tick();
    wait_cyc(2);
    bus_read(2'd0, rd); check("R7 three ticks no timeout", rd, 16'h0000);
    char_tick();
    wait_cyc(1);
    bus_read(2'd0, rd); check("R7 fourth tick timeout", rd, 16'h0800);
    bus_write(2'd0, 16'h0800);
    for (int k = 0; k < 5; k++) char_tick();
    wait_cyc(2);
    bus_read(2'd0, rd); check("R7 fires once", rd, 16'h0000);
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    for (int k = 0; k < 4; k++) char_tick();
    wait_cyc(2);
    bus_read(2'd0, rd); check("R7 rearmed by busy", rd, 16'h0800);
    bus_write(2'd0, 16'h3FFF);
    nempty = 1'b0;
    for (int k = 0; k < 6; k++) char_tick();
    wait_cyc(2);
    bus_read(2'd0, rd); check("R7 empty fifo no timeout", rd, 16'h0000);

    // R1: external pulses on bits 10 and 11 alone, everything enabled
    bus_write(2'd1, 16'h3FFF);
    pulse_evt(14'h0C00);
    wait_cyc(1);
    bus_read(2'd0, rd); check("R1 bits 10 11 ignored", rd, 16'h0000);
    check("R1 no irq", {15'd0, irq}, 16'h0000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule